// File: doc/BRIEF.md
# Coherent Dual-Channel Result Register Bank

This block is a read-only byte-wide register bank that sits between a two-channel converter and a host read port. The converter side presents two 16-bit results and a one-cycle strobe at the end of each integration cycle; the bank loads both values into live registers on that strobe. The host issues reads by register address and receives one byte per read, with a valid flag, one cycle later.

Each 16-bit result is split into a low byte and a high byte. Reading a low byte also copies the upper eight bits of the same channel into a per-channel shadow byte. A later high-byte read returns that shadow byte, so the two halves always come from the same conversion, however many conversions complete between the two reads. A word read at a low-byte address produces both halves on two back-to-back beats. A fixed identification byte, with part and revision fields, is also readable.

Top module: `rbank_top`

## Requirements
- R1: After reset, `rd_valid_o` and `rd_data_o` are 0, both live results are 0x0000 and both shadow bytes are 0x00, so every result address reads 0x00.
- R2: A host read accepted in cycle k (`rd_en_i` high, no word read in progress) drives `rd_valid_o` high with its byte in cycle k+1; with no read, `rd_valid_o` is low in the following cycle.
- R3: Address 0xA reads the constant identification byte, with `PART_ID` in bits 7:4 and `REV_ID` in bits 3:0 (0x50 by default).
- R4: Address 0xC returns bits 7:0 of the channel 0 live result; address 0xE returns bits 7:0 of the channel 1 live result.
- R5: A read of 0xC (0xE) copies bits 15:8 of the channel 0 (1) live result into that channel's shadow byte; a read of 0xD (0xF) returns the shadow byte, even when conversion strobes arrive between the two reads.
- R6: Each channel has its own shadow byte; a low-byte read of one channel leaves the other channel's shadow byte unchanged.
- R7: A high-byte read with no earlier low-byte read of that channel since reset returns 0x00.
- R8: `conv_done_i` loads `ch0_res_i` and `ch1_res_i` into the live results; when it coincides with a low-byte read, the returned byte and the captured shadow byte both come from the value held before the load.
- R9: A read with `word_rd_i` high at 0xC or 0xE yields two beats with `rd_valid_o` high: the low byte, then the matching high byte from the same 16-bit value; a host read strobe in the cycle of the second beat is ignored. `word_rd_i` at any other address gives a single beat.
- R10: Addresses 0x0 to 0x9 and 0xB read as 0x00 with `rd_valid_o` high and change no shadow byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ch0_res_i | input | 16 | Channel 0 conversion result |
| ch1_res_i | input | 16 | Channel 1 conversion result |
| conv_done_i | input | 1 | Conversion-complete strobe, loads both results |
| rd_addr_i | input | 4 | Host register address |
| rd_en_i | input | 1 | Host read strobe |
| word_rd_i | input | 1 | Qualifies the read as a two-byte word read |
| rd_data_o | output | 8 | Read data byte |
| rd_valid_o | output | 1 | Read data valid |

## Verification
On every cycle the assertions check the one-cycle read latency, the live-register load and hold on the conversion strobe, that shadow bytes move only on a low-byte read of their own channel, that high reads return the shadow and low reads the pre-strobe live byte, the identification byte, zero data from unmapped addresses, and the two-beat shape of a word read. Only the bench's scenarios show coherence across a gap of several conversions between the two byte reads, the reset value of a never-captured shadow, cross-channel interleaving, and that a strobe during the second word beat leaves the shadow bytes untouched when they are read back later.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 4;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  localparam logic [ADDR_W-1:0] ID_ADDR  = 4'hA;
  localparam logic [ADDR_W-1:0] RES_BASE = 4'hC;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [DATA_W-1:0] res_t;

  // low byte of channel ch; high byte sits at the next address
  function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
    return RES_BASE + ADDR_W'(2 * ch);
  endfunction
endpackage

// File: rtl/rbank_live.sv
module rbank_live
  import rbank_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  res_t [NUM_CH-1:0]      res_i,
  output res_t [NUM_CH-1:0]      live_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     live_o[c] <= '0;
      else if (load_i) live_o[c] <= res_i[c];
    end
  end
endmodule

// File: rtl/rbank_shadow.sv
module rbank_shadow
  import rbank_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CH-1:0]      load_i,
  input  byte_t [NUM_CH-1:0]     hi_i,
  output byte_t [NUM_CH-1:0]     shadow_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        shadow_o[c] <= '0;
      else if (load_i[c]) shadow_o[c] <= hi_i[c];
    end
  end
endmodule

// File: rtl/rbank_rdmux.sv
module rbank_rdmux
  import rbank_pkg::*;
#(
  parameter logic [3:0] PART_ID = 4'h5,
  parameter logic [3:0] REV_ID  = 4'h0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_en_i,
  input  logic                   word_rd_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  byte_t [NUM_CH-1:0]     live_lo_i,
  input  byte_t [NUM_CH-1:0]     shadow_i,
  output logic [NUM_CH-1:0]      sh_load_o,
  output logic                   word_busy_o,
  output byte_t                  rd_data_o,
  output logic                   rd_valid_o
);
  localparam byte_t ID_BYTE = {PART_ID, REV_ID};

  logic              busy_q;
  logic [CH_W-1:0]   wch_q, wch_d;
  logic              eff_en;
  logic [ADDR_W-1:0] eff_addr;
  logic [NUM_CH-1:0] hit_lo, hit_hi;
  logic              hit_id, word_start;
  byte_t             data_d;

  // second word beat overrides the host port
  always_comb begin
    if (busy_q) begin
      eff_en   = 1'b1;
      eff_addr = lo_addr(int'(wch_q)) + ADDR_W'(1);
    end else begin
      eff_en   = rd_en_i;
      eff_addr = rd_addr_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign hit_lo[c] = eff_en && (eff_addr == lo_addr(c));
    assign hit_hi[c] = eff_en && (eff_addr == lo_addr(c) + ADDR_W'(1));
  end
  assign hit_id    = eff_en && (eff_addr == ID_ADDR);
  assign sh_load_o = hit_lo;

  assign word_start = !busy_q && word_rd_i && (|hit_lo);

  always_comb begin
    wch_d = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (hit_lo[c]) wch_d = CH_W'(c);
  end

  always_comb begin
    data_d = '0;
    if (hit_id) data_d = ID_BYTE;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_lo[c]) data_d = live_lo_i[c];
      if (hit_hi[c]) data_d = shadow_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      wch_q      <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      busy_q     <= word_start;
      if (word_start) wch_q <= wch_d;
      rd_data_o  <= data_d;
      rd_valid_o <= eff_en;
    end
  end

  assign word_busy_o = busy_q;
endmodule

// File: rtl/rbank_top.sv
module rbank_top
  import rbank_pkg::*;
#(
  parameter logic [3:0] PART_ID = 4'h5,
  parameter logic [3:0] REV_ID  = 4'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] ch0_res_i,
  input  logic [15:0] ch1_res_i,
  input  logic        conv_done_i,
  input  logic [3:0]  rd_addr_i,
  input  logic        rd_en_i,
  input  logic        word_rd_i,
  output logic [7:0]  rd_data_o,
  output logic        rd_valid_o
);
  res_t  [NUM_CH-1:0] res_in, live_q;
  byte_t [NUM_CH-1:0] live_lo, live_hi, shadow_q;
  logic  [NUM_CH-1:0] sh_load;
  logic               word_busy;

  assign res_in = {ch1_res_i, ch0_res_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_split
    assign live_lo[c] = live_q[c][BYTE_W-1:0];
    assign live_hi[c] = live_q[c][DATA_W-1:BYTE_W];
  end

  rbank_live u_live (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (conv_done_i),
    .res_i  (res_in),
    .live_o (live_q)
  );

  rbank_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (sh_load),
    .hi_i     (live_hi),
    .shadow_o (shadow_q)
  );

  rbank_rdmux #(
    .PART_ID (PART_ID),
    .REV_ID  (REV_ID)
  ) u_rdmux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .word_rd_i   (word_rd_i),
    .rd_addr_i   (rd_addr_i),
    .live_lo_i   (live_lo),
    .shadow_i    (shadow_q),
    .sh_load_o   (sh_load),
    .word_busy_o (word_busy),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o)
  );
endmodule

// File: rtl/rbank_chk.sv
module rbank_chk
  import rbank_pkg::*;
#(
  parameter logic [3:0] PART_ID = 4'h5,
  parameter logic [3:0] REV_ID  = 4'h0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [15:0]        ch0_res_i,
  input logic [15:0]        ch1_res_i,
  input logic               conv_done_i,
  input logic [3:0]         rd_addr_i,
  input logic               rd_en_i,
  input logic               word_rd_i,
  input logic [7:0]         rd_data_o,
  input logic               rd_valid_o,
  input res_t [NUM_CH-1:0]  live_q,
  input byte_t [NUM_CH-1:0] shadow_q,
  input logic               word_busy
);
  logic acc;
  assign acc = rd_en_i && !word_busy;

  a_r2_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rd_valid_o);
  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && !word_busy) |=> !rd_valid_o);
  a_r3_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rd_addr_i == 4'hA) |=> rd_data_o == {PART_ID, REV_ID});
  a_r4_lo0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rd_addr_i == 4'hC) |=> rd_data_o == $past(live_q[0][7:0]));
  a_r4_lo1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rd_addr_i == 4'hE) |=> rd_data_o == $past(live_q[1][7:0]));
  a_r5_hi0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rd_addr_i == 4'hD) |=> rd_data_o == $past(shadow_q[0]));
  a_r5_cap0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rd_addr_i == 4'hC) |=> shadow_q[0] == $past(live_q[0][15:8]));
  a_r6_hold0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && rd_addr_i == 4'hC) |=> $stable(shadow_q[0]));
  a_r6_hold1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && rd_addr_i == 4'hE) |=> $stable(shadow_q[1]));
  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> (live_q[0] == $past(ch0_res_i) && live_q[1] == $past(ch1_res_i)));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> $stable(live_q));
  a_r9_word0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && word_rd_i && rd_addr_i == 4'hC) |=> rd_valid_o ##1
      (rd_valid_o && rd_data_o == $past(live_q[0][15:8], 2)));
  a_r10_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (rd_addr_i < 4'hA || rd_addr_i == 4'hB)) |=> rd_data_o == 8'h00);
endmodule

bind rbank_top rbank_chk #(
  .PART_ID (PART_ID),
  .REV_ID  (REV_ID)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ch0_res_i   (ch0_res_i),
  .ch1_res_i   (ch1_res_i),
  .conv_done_i (conv_done_i),
  .rd_addr_i   (rd_addr_i),
  .rd_en_i     (rd_en_i),
  .word_rd_i   (word_rd_i),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .live_q      (live_q),
  .shadow_q    (shadow_q),
  .word_busy   (word_busy)
);

// File: tb/rbank_top_tb_top.sv
module rbank_top_tb_top;
  localparam logic [7:0] ID_EXP = 8'h50;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ch0_res_i = '0, ch1_res_i = '0;
  logic        conv_done_i = 1'b0;
  logic [3:0]  rd_addr_i = '0;
  logic        rd_en_i = 1'b0, word_rd_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] m_live [2];
  logic [7:0]  m_sh   [2];

  always #10 clk_i = ~clk_i;

  rbank_top dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .ch0_res_i (ch0_res_i), .ch1_res_i (ch1_res_i), .conv_done_i (conv_done_i),
    .rd_addr_i (rd_addr_i), .rd_en_i (rd_en_i), .word_rd_i (word_rd_i),
    .rd_data_o (rd_data_o), .rd_valid_o (rd_valid_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [3:0] a);
    case (a)
      4'hA: return ID_EXP;
      4'hC: begin m_sh[0] = m_live[0][15:8]; return m_live[0][7:0]; end
      4'hE: begin m_sh[1] = m_live[1][15:8]; return m_live[1][7:0]; end
      4'hD: return m_sh[0];
      4'hF: return m_sh[1];
      default: return 8'h00;
    endcase
  endfunction

  // host read, optionally with a coincident conversion strobe
  task automatic host_rd(input logic [3:0] a, input bit w, input bit cv,
                         input logic [15:0] n0, input logic [15:0] n1, input string req);
    logic [7:0] e1, e2;
    bit two;
    e1  = model_rd(a);
    two = w && (a == 4'hC || a == 4'hE);
    e2  = (a == 4'hC) ? m_sh[0] : m_sh[1];
    rd_en_i = 1'b1; rd_addr_i = a; word_rd_i = w;
    if (cv) begin conv_done_i = 1'b1; ch0_res_i = n0; ch1_res_i = n1; end
    @(negedge clk_i);
    rd_en_i = 1'b0; word_rd_i = 1'b0; conv_done_i = 1'b0;
    if (cv) begin m_live[0] = n0; m_live[1] = n1; end
    check({req, " valid"}, {7'b0, rd_valid_o}, 8'h01);
    check({req, " data"}, rd_data_o, e1);
    if (two) begin
      @(negedge clk_i);
      check({req, " beat2 valid"}, {7'b0, rd_valid_o}, 8'h01);
      check({req, " beat2 data"}, rd_data_o, e2);
    end
  endtask

  task automatic conv(input logic [15:0] n0, input logic [15:0] n1);
    conv_done_i = 1'b1; ch0_res_i = n0; ch1_res_i = n1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    m_live[0] = n0; m_live[1] = n1;
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk_i);
    check({req, " idle valid"}, {7'b0, rd_valid_o}, 8'h00);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v0, v1;
    m_live[0] = '0; m_live[1] = '0; m_sh[0] = '0; m_sh[1] = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 reset valid", {7'b0, rd_valid_o}, 8'h00);
    check("R1 reset data", rd_data_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    conv(16'hA5C3, 16'h3C5A);
    // R7: high bytes never captured read 0
    host_rd(4'hD, 0, 0, 0, 0, "R7 hi0 before lo");
    host_rd(4'hF, 0, 0, 0, 0, "R7 hi1 before lo");
    idle_chk("R2");
    // R3/R10: sweep every address
    for (int a = 0; a < 16; a++)
      host_rd(4'(a), 0, 0, 0, 0, "R10 R3 R4 R5 sweep");

    for (int p = 0; p < 8; p++) begin
      v0 = 16'(p * 16'h1357 + 16'h00F1);
      v1 = ~v0 ^ 16'(p << 9);
      conv(v0, v1);
      for (int a = 0; a < 16; a++)
        host_rd(4'(a), 0, 0, 0, 0, "R4 R5 R10 sweep");
      // R5: several conversions between low and high reads
      host_rd(4'hC, 0, 0, 0, 0, "R4 lo0");
      conv(v0 ^ 16'hFFFF, v1 + 16'h0101);
      conv(v0 + 16'h4321, v1 ^ 16'h8000);
      host_rd(4'hD, 0, 0, 0, 0, "R5 hi0 coherent");
      // R6: interleaved channels
      host_rd(4'hE, 0, 0, 0, 0, "R6 lo1");
      conv(16'(v0 * 3), 16'(v1 * 5));
      host_rd(4'hC, 0, 0, 0, 0, "R6 lo0");
      host_rd(4'hF, 0, 0, 0, 0, "R6 hi1 untouched");
      host_rd(4'hD, 0, 0, 0, 0, "R6 hi0");
      // R8: strobe coincides with low read
      host_rd(4'hE, 0, 1, 16'(v0 + 16'h7777), 16'(v1 - 16'h1111), "R8 lo1 pre-update");
      host_rd(4'hF, 0, 0, 0, 0, "R8 hi1 pre-update");
      host_rd(4'hC, 0, 1, 16'(v1), 16'(v0), "R8 lo0 pre-update");
      host_rd(4'hD, 0, 0, 0, 0, "R8 hi0 pre-update");
      // R9: word reads
      host_rd(4'hC, 1, 0, 0, 0, "R9 word ch0");
      host_rd(4'hE, 1, 0, 0, 0, "R9 word ch1");
      idle_chk("R9");
      // R10: unmapped reads change no shadow
      host_rd(4'hC, 0, 0, 0, 0, "R10 lo0");
      host_rd(4'(p), 0, 0, 0, 0, "R10 unmapped");
      host_rd(4'hB, 0, 0, 0, 0, "R10 unmapped B");
      host_rd(4'hD, 0, 0, 0, 0, "R10 hi0 unchanged");
    end

    // R9: host strobe during second beat is ignored
    conv(16'h1122, 16'h3344);
    host_rd(4'hE, 0, 0, 0, 0, "R9 prime ch1");
    conv(16'h5566, 16'h7788);
    rd_en_i = 1'b1; rd_addr_i = 4'hC; word_rd_i = 1'b1;
    void'(model_rd(4'hC));
    @(negedge clk_i);
    rd_addr_i = 4'hE; word_rd_i = 1'b0;
    check("R9 beat1", rd_data_o, 8'h66);
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check("R9 beat2", rd_data_o, 8'h55);
    check("R9 beat2 valid", {7'b0, rd_valid_o}, 8'h01);
    idle_chk("R9 ignored strobe");
    host_rd(4'hF, 0, 0, 0, 0, "R9 hi1 unchanged");
    check("R9 hi1 value", m_sh[1], 8'h33);
    // R9: word qualifier off a low address gives one beat
    host_rd(4'hD, 1, 0, 0, 0, "R9 word at hi");
    idle_chk("R9 single beat");
    host_rd(4'hA, 1, 0, 0, 0, "R9 R3 word at id");
    idle_chk("R9 single beat id");

    summary();
    $finish;
  end
endmodule